// File: doc/BRIEF.md
# DMA Minor-Loop Address Update

This block produces the write-back source and destination addresses for one DMA channel at the moment its minor loop retires. The channel engine presents the descriptor's current addresses, its 32-bit byte-count word and the two major-loop last adjustments. With these it presents a global mapping-mode input and a flag saying whether the major loop has also run out. It then pulses an update request.

In mapping mode the byte-count word is split. It carries two enables, one per direction, and a signed offset that both directions share. The byte count takes whatever space is left. The block decodes that word, chooses for each direction between the major-loop adjustment, the shared offset and no change, and registers the result. The result appears one cycle after the request, marked by a single-cycle valid pulse.

Top module: `dma_mloop_addr_upd`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after reset is released, `saddr_o`, `daddr_o` and `nbytes_o` read zero and `valid_o` is low.
- R2: `valid_o` is high in exactly the cycle that follows a cycle with `upd_i` high. The outputs of that update appear in the same cycle as the pulse.
- R3: With `map_en_i` low, `nbytes_o` equals all 32 bits of `nbytes_word_i`, and no minor-loop offset is applied to either address.
- R4: With `map_en_i` high and word bits 31 and 30 both clear, `nbytes_o` equals word bits 29:0 zero-extended, and no offset is applied.
- R5: With `map_en_i` high and word bit 31 or bit 30 set, `nbytes_o` equals word bits 9:0 zero-extended. The offset is word bits 29:10, read as 20-bit two's complement and sign-extended to 32 bits.
- R6: With mapping on, the major loop not done and bit 31 (source enable) set, `saddr_o` equals `saddr_i` plus the offset. With bit 31 clear, `saddr_o` equals `saddr_i`.
- R7: With mapping on, the major loop not done and bit 30 (destination enable) set, `daddr_o` equals `daddr_i` plus the offset. With bit 30 clear, `daddr_o` equals `daddr_i`.
- R8: When both enables are set, the same offset value is added to both addresses.
- R9: With `major_done_i` high, `saddr_o` equals `saddr_i + slast_i` and `daddr_o` equals `daddr_i + dlast_i`, whatever the mapping mode and enables.
- R10: In a cycle with `upd_i` low, all three data outputs keep their values, however the other inputs change.
- R11: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Minor-loop completion update request |
| map_en_i | input | 1 | Global mapping mode for the byte-count word |
| major_done_i | input | 1 | Major loop completes with this minor loop |
| saddr_i | input | 32 | Final source address of the minor loop |
| daddr_i | input | 32 | Final destination address of the minor loop |
| nbytes_word_i | input | 32 | Descriptor byte-count word |
| slast_i | input | 32 | Source adjustment applied at major-loop end |
| dlast_i | input | 32 | Destination adjustment applied at major-loop end |
| saddr_o | output | 32 | Write-back source address |
| daddr_o | output | 32 | Write-back destination address |
| nbytes_o | output | 32 | Decoded byte count |
| valid_o | output | 1 | Single-cycle strobe for the outputs |

## Verification
The bench sweeps every combination of mapping mode, major-done flag and the two enables. It uses offsets at the positive and negative extremes of the 20-bit field, and address sets chosen so that sums cross the 32-bit boundary.

Each bug under test shows up at the outputs in its own way:
- A decoder that zero-extends the offset moves addresses forward when they should move back.
- A decoder that takes the wrong count width leaks offset bits into `nbytes_o`.
- A design that lets the minor-loop offset win over the major-loop adjustment writes back a mid-loop address after the major loop has ended.
- Idle cycles with changing inputs expose any output that fails to hold.

// File: rtl/dma_mloop_pkg.sv
package dma_mloop_pkg;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned WORD_W = 32;

  typedef struct packed {
    logic              src_en;
    logic              dst_en;
    logic [ADDR_W-1:0] off;
    logic [WORD_W-1:0] nbytes;
  } mloop_dec_t;
endpackage

// File: rtl/dma_mloop_decode.sv
module dma_mloop_decode
  import dma_mloop_pkg::*;
#(
  parameter int unsigned OFF_W      = 20,
  parameter int unsigned SHORT_NB_W = 10
) (
  input  logic              map_en_i,
  input  logic [WORD_W-1:0] word_i,
  output mloop_dec_t        dec_o
);
  localparam int unsigned SRC_BIT   = WORD_W - 1;
  localparam int unsigned DST_BIT   = WORD_W - 2;
  localparam int unsigned LONG_NB_W = WORD_W - 2;
  localparam int unsigned OFF_LSB   = SHORT_NB_W;
  localparam int unsigned OFF_MSB   = OFF_LSB + OFF_W - 1;

  logic any_en;
  assign any_en = word_i[SRC_BIT] | word_i[DST_BIT];

  always_comb begin
    dec_o = '0;
    if (!map_en_i) begin
      dec_o.nbytes = word_i;
    end else begin
      dec_o.src_en = word_i[SRC_BIT];
      dec_o.dst_en = word_i[DST_BIT];
      dec_o.off    = {{(ADDR_W-OFF_W){word_i[OFF_MSB]}}, word_i[OFF_MSB:OFF_LSB]};
      if (any_en)
        dec_o.nbytes = {{(WORD_W-SHORT_NB_W){1'b0}}, word_i[SHORT_NB_W-1:0]};
      else
        dec_o.nbytes = {{(WORD_W-LONG_NB_W){1'b0}}, word_i[LONG_NB_W-1:0]};
    end
  end
endmodule

// File: rtl/dma_mloop_addr_step.sv
module dma_mloop_addr_step
  import dma_mloop_pkg::*;
(
  input  logic              major_done_i,
  input  logic              off_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [ADDR_W-1:0] last_i,
  output logic [ADDR_W-1:0] next_o
);
  // major-loop adjustment wins over the minor-loop offset
  always_comb begin
    if (major_done_i)  next_o = addr_i + last_i;
    else if (off_en_i) next_o = addr_i + off_i;
    else               next_o = addr_i;
  end
endmodule

// File: rtl/dma_mloop_addr_upd.sv
module dma_mloop_addr_upd
  import dma_mloop_pkg::*;
#(
  parameter int unsigned OFF_W      = 20,
  parameter int unsigned SHORT_NB_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              map_en_i,
  input  logic              major_done_i,
  input  logic [ADDR_W-1:0] saddr_i,
  input  logic [ADDR_W-1:0] daddr_i,
  input  logic [WORD_W-1:0] nbytes_word_i,
  input  logic [ADDR_W-1:0] slast_i,
  input  logic [ADDR_W-1:0] dlast_i,
  output logic [ADDR_W-1:0] saddr_o,
  output logic [ADDR_W-1:0] daddr_o,
  output logic [WORD_W-1:0] nbytes_o,
  output logic              valid_o
);
  localparam int unsigned N_DIR = 2; // 0 source, 1 destination

  mloop_dec_t        dec;
  logic [ADDR_W-1:0] cur_addr [N_DIR];
  logic [ADDR_W-1:0] last_adj [N_DIR];
  logic [ADDR_W-1:0] nxt_addr [N_DIR];
  logic              dir_en   [N_DIR];

  dma_mloop_decode #(.OFF_W(OFF_W), .SHORT_NB_W(SHORT_NB_W)) u_dec (
    .map_en_i (map_en_i),
    .word_i   (nbytes_word_i),
    .dec_o    (dec)
  );

  assign cur_addr[0] = saddr_i;
  assign cur_addr[1] = daddr_i;
  assign last_adj[0] = slast_i;
  assign last_adj[1] = dlast_i;
  assign dir_en[0]   = dec.src_en;
  assign dir_en[1]   = dec.dst_en;

  for (genvar g = 0; g < N_DIR; g++) begin : g_dir
    dma_mloop_addr_step u_step (
      .major_done_i (major_done_i),
      .off_en_i     (dir_en[g]),
      .addr_i       (cur_addr[g]),
      .off_i        (dec.off),
      .last_i       (last_adj[g]),
      .next_o       (nxt_addr[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      saddr_o  <= '0;
      daddr_o  <= '0;
      nbytes_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= upd_i;
      if (upd_i) begin
        saddr_o  <= nxt_addr[0];
        daddr_o  <= nxt_addr[1];
        nbytes_o <= dec.nbytes;
      end
    end
  end
endmodule

// File: rtl/dma_mloop_addr_upd_chk.sv
module dma_mloop_addr_upd_chk
  import dma_mloop_pkg::*;
#(
  parameter int unsigned SHORT_NB_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_i,
  input logic              map_en_i,
  input logic              major_done_i,
  input logic [ADDR_W-1:0] saddr_i,
  input logic [ADDR_W-1:0] daddr_i,
  input logic [WORD_W-1:0] nbytes_word_i,
  input logic [ADDR_W-1:0] slast_i,
  input logic [ADDR_W-1:0] dlast_i,
  input logic [ADDR_W-1:0] saddr_o,
  input logic [ADDR_W-1:0] daddr_o,
  input logic [WORD_W-1:0] nbytes_o,
  input logic              valid_o
);
  logic any_en;
  assign any_en = nbytes_word_i[WORD_W-1] | nbytes_word_i[WORD_W-2];

  // R2
  valid_after_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> valid_o);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> !valid_o);
  // R10
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(saddr_o) && $stable(daddr_o) && $stable(nbytes_o)));
  // R9
  major_adjust_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && major_done_i) |=>
      (saddr_o == $past(saddr_i + slast_i) && daddr_o == $past(daddr_i + dlast_i)));
  // R3
  full_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !map_en_i) |=> nbytes_o == $past(nbytes_word_i));
  // R4
  no_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !major_done_i && (!map_en_i || !any_en)) |=>
      (saddr_o == $past(saddr_i) && daddr_o == $past(daddr_i)));
  // R5
  short_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && map_en_i && any_en) |=> (nbytes_o >> SHORT_NB_W) == '0);
endmodule

bind dma_mloop_addr_upd dma_mloop_addr_upd_chk #(.SHORT_NB_W(SHORT_NB_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .upd_i         (upd_i),
  .map_en_i      (map_en_i),
  .major_done_i  (major_done_i),
  .saddr_i       (saddr_i),
  .daddr_i       (daddr_i),
  .nbytes_word_i (nbytes_word_i),
  .slast_i       (slast_i),
  .dlast_i       (dlast_i),
  .saddr_o       (saddr_o),
  .daddr_o       (daddr_o),
  .nbytes_o      (nbytes_o),
  .valid_o       (valid_o)
);

// File: tb/dma_mloop_addr_upd_test.sv
`timescale 1ns/1ps
module dma_mloop_addr_upd_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        upd_i = 1'b0;
  logic        map_en_i = 1'b0;
  logic        major_done_i = 1'b0;
  logic [31:0] saddr_i = '0, daddr_i = '0, nbytes_word_i = '0, slast_i = '0, dlast_i = '0;
  logic [31:0] saddr_o, daddr_o, nbytes_o;
  logic        valid_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  dma_mloop_addr_upd uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd_i), .map_en_i(map_en_i),
    .major_done_i(major_done_i), .saddr_i(saddr_i), .daddr_i(daddr_i),
    .nbytes_word_i(nbytes_word_i), .slast_i(slast_i), .dlast_i(dlast_i),
    .saddr_o(saddr_o), .daddr_o(daddr_o), .nbytes_o(nbytes_o), .valid_o(valid_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // one update followed by an idle cycle with scrambled inputs
  task automatic run_case(input logic map, input logic maj, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] w, input logic [31:0] sl, input logic [31:0] dl);
    logic        se, de;
    logic [31:0] off, es, ed, en;
    string       rs, rd, rn;
    se  = map & w[31];
    de  = map & w[30];
    off = {{12{w[29]}}, w[29:10]};
    if (!map)          begin en = w;                 rn = "R3"; end
    else if (se || de) begin en = {22'd0, w[9:0]};   rn = "R5"; end
    else               begin en = {2'b00, w[29:0]};  rn = "R4"; end
    if (maj)     begin es = s + sl;  rs = "R9"; end
    else if (se) begin es = s + off; rs = de ? "R8" : "R6"; end
    else         begin es = s;       rs = map ? "R6" : "R3"; end
    if (maj)     begin ed = d + dl;  rd = "R9"; end
    else if (de) begin ed = d + off; rd = se ? "R8" : "R7"; end
    else         begin ed = d;       rd = map ? "R7" : "R3"; end
    @(negedge clk_i);
    map_en_i = map; major_done_i = maj; saddr_i = s; daddr_i = d;
    nbytes_word_i = w; slast_i = sl; dlast_i = dl; upd_i = 1'b1;
    @(negedge clk_i);
    chk("R2", "valid", {31'd0, valid_o}, 32'd1);
    chk(rs, "saddr", saddr_o, es);
    chk(rd, "daddr", daddr_o, ed);
    chk(rn, "nbytes", nbytes_o, en);
    upd_i = 1'b0;
    saddr_i = ~s; daddr_i = ~d; nbytes_word_i = ~w; major_done_i = ~maj; map_en_i = ~map;
    @(negedge clk_i);
    chk("R2", "valid idle", {31'd0, valid_o}, 32'd0);
    chk("R10", "saddr hold", saddr_o, es);
    chk("R10", "daddr hold", daddr_o, ed);
    chk("R10", "nbytes hold", nbytes_o, en);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R2 watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] sa [2];
    logic [31:0] da [2];
    logic [31:0] sl [2];
    logic [31:0] dl [2];
    logic [19:0] offs [4];
    sa[0] = 32'h1000_0000; da[0] = 32'h2000_0040; sl[0] = 32'hFFFF_F000; dl[0] = 32'h0000_0100;
    // R11 wrap set: sums cross 2^32 in both directions
    sa[1] = 32'hFFFF_FFF8; da[1] = 32'h0000_0004; sl[1] = 32'h0000_0010; dl[1] = 32'hFFFF_FFF0;
    offs[0] = 20'h00001; offs[1] = 20'h7FFFF; offs[2] = 20'h80000; offs[3] = 20'hFFFFF;

    repeat (3) @(negedge clk_i);
    // R1 during reset
    chk("R1", "valid in reset", {31'd0, valid_o}, 32'd0);
    chk("R1", "saddr in reset", saddr_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "saddr after reset", saddr_o, 32'd0);
    chk("R1", "daddr after reset", daddr_o, 32'd0);
    chk("R1", "nbytes after reset", nbytes_o, 32'd0);
    chk("R1", "valid after reset", {31'd0, valid_o}, 32'd0);

    for (int a = 0; a < 2; a++)
      for (int m = 0; m < 2; m++)
        for (int j = 0; j < 2; j++)
          for (int e = 0; e < 4; e++)
            for (int o = 0; o < 4; o++)
              for (int c = 0; c < 2; c++) begin
                logic [31:0] w;
                w = {e[1], e[0], offs[o], (c == 0) ? 10'h3FF : 10'h155};
                run_case(m[0], j[0], sa[a], da[a], w, sl[a], dl[a]);
              end

    // R11 explicit: offset -8 from low source address wraps to top of space
    run_case(1'b1, 1'b0, 32'h0000_0004, 32'hFFFF_FFFC, {2'b11, 20'hFFFF8, 10'h001}, '0, '0);

    summary();
    $finish;
  end
endmodule